// File: doc/BRIEF.md
# Virtualization CSR Swap Bank

This block keeps two copies of the supervisor trap registers. The registers are status, interrupt-pending, interrupt-enable, trap vector, scratch, exception PC, cause, trap value and translation pointer. The foreground copy is the set that the running supervisor sees. The background copy holds the other context.

While the virtualization bit V is 0, the background copy holds the guest's state. While V is 1, it holds the host supervisor's state. A one-cycle strobe proposes a new V. When the proposed value differs from the current one, both copies trade places on that same clock edge. The status register and the two interrupt registers trade only their defined fields; the other six registers trade whole words.

A single CSR port reaches both name sets. Background names are legal only from the host at supervisor or machine privilege. The bank is a two-state machine:
- MODE_HOST is V=0.
- MODE_GUEST is V=1.
- The transition "enter guest" (strobe with value 1 in MODE_HOST) and the transition "leave guest" (strobe with value 0 in MODE_GUEST) each swap the copies.
- A strobe that carries the current value is ignored.

The translation walker reads both pointer copies through dedicated outputs.

Top module: `vswap_csr_bank`

## Requirements
- R1: After reset, V is 0 and every foreground and background register reads as zero.
- R2: On a change of V, in either direction, the foreground and background copies of trap vector (index 3), scratch (4), exception PC (5), cause (6), trap value (7) and translation pointer (8) exchange their full contents on that clock edge.
- R3: On a change of V, the status register (index 0) exchanges only bits 1, 5, 8, 13, 14, 18, 19, 32 and 33 (mask 64'h0000_0003_000C_6122) with its background copy. All other bits of both copies keep their values.
- R4: On a change of V, the interrupt-pending (index 1) and interrupt-enable (index 2) registers exchange only bits 0, 1, 4, 5, 8 and 9 (mask 12'h333). Their other bits stay in place.
- R5: A strobe whose value equals the current V changes nothing: V holds and no register moves.
- R6: A background name (address bit 4 set) is legal only while V=0 and privilege is 1 (host supervisor) or 3 (machine). Any other background access raises csr_illegal in the same cycle, returns zero read data, and is not written.
- R7: An address whose low four bits exceed 8 is illegal under any mode: csr_illegal rises, read data is zero and nothing is written.
- R8: irq_ext_pend is ORed into bit 9 of foreground pending read data only. Background pending bit 9 returns exactly what was written.
- R9: A CSR write in the same cycle as a V change lands in the post-swap mapping: a foreground write ends up in the new foreground, and the old foreground value moves to the background.
- R10: atp_fg and atp_bg always show the current foreground and background translation-pointer registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| v_set_valid | input | 1 | One-cycle strobe proposing a new V |
| v_set_value | input | 1 | Proposed V value |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| csr_en | input | 1 | CSR access this cycle |
| csr_we | input | 1 | Access is a write (with csr_en) |
| csr_addr | input | 5 | Bit 4 selects background; bits 3:0 are the register index 0..8 |
| csr_wdata | input | XLEN | Write data |
| irq_ext_pend | input | 1 | External pending level merged into foreground pending bit 9 on read |
| csr_rdata | output | XLEN | Combinational read data, zero when idle or illegal |
| csr_illegal | output | 1 | Access violates the access rules |
| v_cur | output | 1 | Current virtualization bit |
| atp_fg | output | XLEN | Foreground translation pointer |
| atp_bg | output | XLEN | Background translation pointer |

## Verification
The word registers are loaded with distinct foreground and background patterns, so that a swap, a missing swap and a one-sided copy each give a different read value. The status register starts with all ones in front and high-only bits behind. Pending and enable start as complementary ones and zeros. A round trip therefore exposes any bit inside or outside the masks that moves wrongly. Repeated same-value strobes, background writes from the guest or user mode, and a write that coincides with a swap separate a correct mapping from one that acts on the pre-swap layout or lets a blocked write through.

// File: rtl/vswap_pkg.sv
package vswap_pkg;
    localparam int NREG   = 9;
    localparam int IDX_W  = 4;
    localparam int ADDR_W = IDX_W + 1;

    localparam int I_STATUS  = 0;
    localparam int I_PEND    = 1;
    localparam int I_ENAB    = 2;
    localparam int I_VEC     = 3;
    localparam int I_SCRATCH = 4;
    localparam int I_EPC     = 5;
    localparam int I_CAUSE   = 6;
    localparam int I_TVAL    = 7;
    localparam int I_ATP     = 8;

    localparam int SEIP_BIT = 9;

    localparam logic [1:0] PRV_HS = 2'd1;
    localparam logic [1:0] PRV_MM = 2'd3;

    typedef enum logic {
        MODE_HOST  = 1'b0,
        MODE_GUEST = 1'b1
    } vmode_e;

    // Fields that trade places on a change of V; unlisted registers trade whole words.
    function automatic logic [63:0] lane_mask(input int unsigned i);
        logic [63:0] m;
        m = '1;
        if (i == I_STATUS) begin
            m = '0;
            m[1] = 1'b1;  m[5] = 1'b1;  m[8] = 1'b1;
            m[13] = 1'b1; m[14] = 1'b1; m[18] = 1'b1;
            m[19] = 1'b1; m[32] = 1'b1; m[33] = 1'b1;
        end else if (i == I_PEND || i == I_ENAB) begin
            m = 64'h333;
        end
        return m;
    endfunction
endpackage

// File: rtl/vswap_access_chk.sv
module vswap_access_chk
    import vswap_pkg::*;
(
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        priv,
    input  logic              v,
    output logic              is_bg,
    output logic [IDX_W-1:0]  idx,
    output logic              ok,
    output logic              bad
);
    logic known;
    logic bg_allowed;

    always_comb begin
        is_bg      = addr[ADDR_W-1];
        idx        = addr[IDX_W-1:0];
        known      = idx < IDX_W'(NREG);
        bg_allowed = !v && (priv == PRV_HS || priv == PRV_MM);
        ok         = known && (!is_bg || bg_allowed);
        bad        = en && !ok;
    end
endmodule

// File: rtl/vswap_reg_pair.sv
module vswap_reg_pair #(
    parameter int               XLEN      = 64,
    parameter logic [XLEN-1:0]  SWAP_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            swap,
    input  logic            wr_fg,
    input  logic            wr_bg,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] fg_q,
    output logic [XLEN-1:0] bg_q
);
    logic [XLEN-1:0] fg_sw, bg_sw, fg_d, bg_d;

    always_comb begin
        fg_sw = fg_q;
        bg_sw = bg_q;
        if (swap) begin
            fg_sw = (fg_q & ~SWAP_MASK) | (bg_q & SWAP_MASK);
            bg_sw = (bg_q & ~SWAP_MASK) | (fg_q & SWAP_MASK);
        end
        // A write lands after the exchange, in the new mapping.
        fg_d = wr_fg ? wdata : fg_sw;
        bg_d = wr_bg ? wdata : bg_sw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fg_q <= '0;
            bg_q <= '0;
        end else begin
            fg_q <= fg_d;
            bg_q <= bg_d;
        end
    end
endmodule

// File: rtl/vswap_csr_bank.sv
module vswap_csr_bank
    import vswap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              v_set_valid,
    input  logic              v_set_value,
    input  logic [1:0]        priv,
    input  logic              csr_en,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              irq_ext_pend,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    output logic              v_cur,
    output logic [XLEN-1:0]   atp_fg,
    output logic [XLEN-1:0]   atp_bg
);
    vmode_e mode_q, mode_d;
    logic   swap_go;

    logic             acc_bg, acc_ok, acc_bad;
    logic [IDX_W-1:0] acc_idx;

    logic [XLEN-1:0] fg_q [NREG];
    logic [XLEN-1:0] bg_q [NREG];

    // Next-state and swap strobe.
    always_comb begin
        mode_d  = mode_q;
        swap_go = 1'b0;
        unique case (mode_q)
            MODE_HOST: begin
                if (v_set_valid && v_set_value) begin
                    mode_d  = MODE_GUEST;
                    swap_go = 1'b1;
                end
            end
            MODE_GUEST: begin
                if (v_set_valid && !v_set_value) begin
                    mode_d  = MODE_HOST;
                    swap_go = 1'b1;
                end
            end
            default: mode_d = MODE_HOST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_HOST;
        else        mode_q <= mode_d;
    end

    vswap_access_chk u_acc (
        .en    (csr_en),
        .addr  (csr_addr),
        .priv  (priv),
        .v     (mode_q == MODE_GUEST),
        .is_bg (acc_bg),
        .idx   (acc_idx),
        .ok    (acc_ok),
        .bad   (acc_bad)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_pair
        localparam logic [XLEN-1:0] MASK = XLEN'(lane_mask(g));
        logic hit;
        assign hit = csr_en && csr_we && acc_ok && (acc_idx == IDX_W'(g));
        vswap_reg_pair #(
            .XLEN      (XLEN),
            .SWAP_MASK (MASK)
        ) u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .swap  (swap_go),
            .wr_fg (hit && !acc_bg),
            .wr_bg (hit && acc_bg),
            .wdata (csr_wdata),
            .fg_q  (fg_q[g]),
            .bg_q  (bg_q[g])
        );
    end

    // Outputs.
    always_comb begin
        csr_rdata = '0;
        if (csr_en && acc_ok) begin
            csr_rdata = acc_bg ? bg_q[acc_idx] : fg_q[acc_idx];
            if (!acc_bg && acc_idx == IDX_W'(I_PEND))
                csr_rdata[SEIP_BIT] = fg_q[I_PEND][SEIP_BIT] | irq_ext_pend;
        end
        csr_illegal = acc_bad;
        v_cur       = (mode_q == MODE_GUEST);
        atp_fg      = fg_q[I_ATP];
        atp_bg      = bg_q[I_ATP];
    end
endmodule

// File: rtl/vswap_csr_bank_sva.sv
module vswap_csr_bank_sva
    import vswap_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              v_set_valid,
    input logic              v_set_value,
    input logic              csr_en,
    input logic              csr_we,
    input logic [ADDR_W-1:0] csr_addr,
    input logic [XLEN-1:0]   csr_rdata,
    input logic              csr_illegal,
    input logic              v_cur,
    input logic [XLEN-1:0]   atp_fg,
    input logic [XLEN-1:0]   atp_bg
);
    a_r5_v_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        v_set_valid |=> v_cur == $past(v_set_value));

    a_r5_v_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !v_set_valid |=> $stable(v_cur));

    a_r2_atp_exchange: assert property (@(posedge clk) disable iff (!rst_n)
        (v_set_valid && v_set_value != v_cur && !(csr_en && csr_we))
        |=> (atp_fg == $past(atp_bg)) && (atp_bg == $past(atp_fg)));

    a_r10_atp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!(v_set_valid && v_set_value != v_cur) && !(csr_en && csr_we))
        |=> $stable(atp_fg) && $stable(atp_bg));

    a_r6_guest_bg_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_addr[ADDR_W-1] && v_cur) |-> csr_illegal);

    a_r6_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == '0);

    a_r7_unknown_index: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_addr[IDX_W-1:0] > IDX_W'(NREG - 1)) |-> csr_illegal);
endmodule

bind vswap_csr_bank vswap_csr_bank_sva #(.XLEN(XLEN)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .v_set_valid (v_set_valid),
    .v_set_value (v_set_value),
    .csr_en      (csr_en),
    .csr_we      (csr_we),
    .csr_addr    (csr_addr),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .v_cur       (v_cur),
    .atp_fg      (atp_fg),
    .atp_bg      (atp_bg)
);

// File: tb/vswap_csr_bank_tb_top.sv
module vswap_csr_bank_tb_top;
    localparam logic [63:0] SMASK = 64'h0000_0003_000C_6122;
    localparam logic [63:0] IMASK = 64'h333;
    localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] SBG   = 64'hF000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v_set_valid = 1'b0, v_set_value = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        csr_en = 1'b0, csr_we = 1'b0;
    logic [4:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic        irq_ext_pend = 1'b0;
    logic [63:0] csr_rdata, atp_fg, atp_bg;
    logic        csr_illegal, v_cur;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] rd;
        logic        ill;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    vswap_csr_bank #(.XLEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .v_set_valid(v_set_valid), .v_set_value(v_set_value),
        .priv(priv), .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .irq_ext_pend(irq_ext_pend), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .v_cur(v_cur), .atp_fg(atp_fg), .atp_bg(atp_bg)
    );

    // Monitor: compares the item pushed in this cycle away from the rising edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            n_run++;
            if (csr_rdata !== it.rd || csr_illegal !== it.ill) begin
                n_fail++;
                $display("FAIL %s: rdata=%h ill=%b expected rdata=%h ill=%b",
                         it.tag, csr_rdata, csr_illegal, it.rd, it.ill);
            end
        end
    end

    function automatic logic [4:0] fa(input int i); return 5'(i); endfunction
    function automatic logic [4:0] ba(input int i); return 5'h10 | 5'(i); endfunction
    function automatic logic [63:0] pa(input int i); return 64'hA000_0000_0000_0000 + 64'(i); endfunction
    function automatic logic [63:0] pb(input int i); return 64'h0B00_0000_0000_0000 + 64'(i); endfunction

    task automatic op(input bit en, input bit we, input logic [4:0] a, input logic [63:0] d,
                      input bit vv, input bit vval, input bit chk,
                      input logic [63:0] exp, input bit ill, input string tag);
        @(posedge clk); #1;
        csr_en = en; csr_we = we; csr_addr = a; csr_wdata = d;
        v_set_valid = vv; v_set_value = vval;
        if (chk) sb.push_back('{exp, ill, tag});
        @(posedge clk); #1;
        csr_en = 0; csr_we = 0; v_set_valid = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        op(1, 1, a, d, 0, 0, 0, '0, 0, "");
    endtask
    task automatic rd(input logic [4:0] a, input logic [63:0] e, input string tag);
        op(1, 0, a, '0, 0, 0, 1, e, 0, tag);
    endtask
    task automatic bad(input logic [4:0] a, input bit we, input string tag);
        op(1, we, a, 64'hDEAD, 0, 0, 1, '0, 1, tag);
    endtask
    task automatic vset(input bit val);
        op(0, 0, '0, '0, 1, val, 0, '0, 0, "");
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk(64'(v_cur), 64'd0, "R1 v_cur after reset");
        for (int i = 0; i < 9; i++) begin
            rd(fa(i), '0, "R1 foreground zero");
            rd(ba(i), '0, "R1 background zero");
        end

        // Load patterns at V=0, machine privilege
        for (int i = 3; i < 9; i++) begin
            wr(fa(i), pa(i));
            wr(ba(i), pb(i));
        end
        wr(fa(0), ONES);  wr(ba(0), SBG);
        wr(fa(1), 64'hFFFF); wr(ba(1), '0);
        wr(fa(2), '0);    wr(ba(2), ONES);

        // enter guest
        vset(1);
        chk(64'(v_cur), 64'd1, "R5 v_cur after enter");
        chk(atp_fg, pb(8), "R10 atp_fg after enter");
        chk(atp_bg, pa(8), "R10 atp_bg after enter");
        for (int i = 3; i < 9; i++) rd(fa(i), pb(i), "R2 foreground after enter");
        rd(fa(0), ~SMASK, "R3 status after enter");
        rd(fa(1), 64'hFCCC, "R4 pending after enter");
        rd(fa(2), IMASK, "R4 enable after enter");
        bad(ba(4), 1, "R6 guest write to background");
        bad(ba(0), 0, "R6 guest read of background");

        // same-value strobe
        vset(1);
        chk(64'(v_cur), 64'd1, "R5 v_cur after repeat strobe");
        rd(fa(3), pb(3), "R5 no swap on repeat strobe");

        // leave guest
        vset(0);
        chk(64'(v_cur), 64'd0, "R5 v_cur after leave");
        chk(atp_fg, pa(8), "R2 atp_fg round trip");
        for (int i = 3; i < 9; i++) begin
            rd(fa(i), pa(i), "R2 foreground round trip");
            rd(ba(i), pb(i), "R2 background round trip (R6 write dropped)");
        end
        rd(fa(0), ONES, "R3 status foreground round trip");
        rd(ba(0), SBG, "R3 status background bits outside mask kept");
        rd(fa(1), 64'hFFFF, "R4 pending round trip");
        rd(ba(2), ONES, "R4 enable background round trip");

        vset(0);
        rd(fa(3), pa(3), "R5 no swap on repeat strobe in host");

        // privilege rules
        priv = 2'd0;
        bad(ba(5), 0, "R6 user read of background");
        bad(ba(5), 1, "R6 user write to background");
        priv = 2'd2;
        bad(ba(5), 0, "R6 reserved privilege read of background");
        priv = 2'd1;
        rd(ba(5), pb(5), "R6 supervisor read of background");
        priv = 2'd3;
        rd(ba(5), pb(5), "R6 background untouched by blocked writes");

        // unknown index
        bad(fa(9), 0, "R7 index 9 foreground");
        bad(ba(15), 0, "R7 index 15 background");
        bad(fa(12), 1, "R7 write to index 12");

        // external pending merge
        wr(fa(1), '0);
        wr(ba(1), '0);
        irq_ext_pend = 1'b1;
        rd(fa(1), 64'h200, "R8 external pending on foreground");
        rd(ba(1), '0, "R8 background pending not driven");
        wr(ba(1), 64'h200);
        rd(ba(1), 64'h200, "R8 background pending storage");
        irq_ext_pend = 1'b0;
        rd(fa(1), '0, "R8 foreground bit not stored");

        // write in the swap cycle
        op(1, 1, fa(4), 64'h5555, 1, 1, 0, '0, 0, "");
        chk(64'(v_cur), 64'd1, "R9 v_cur after combined enter");
        rd(fa(4), 64'h5555, "R9 write lands in new foreground");
        vset(0);
        rd(fa(4), pa(4), "R9 old foreground moved to background");
        rd(ba(4), 64'h5555, "R9 written value now background");

        done = 1;
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule